// File: doc/BRIEF.md
# Four-Channel Multimode PWM Generator

This block produces four pulse-width-modulated outputs. Each channel has its own counter, a writable period value and a writable pulse-width value. The period and pulse-width values are double-buffered: software writes the working copy at any time, and the channel copies it into a shadow copy whenever a new PWM cycle begins. A 16-bit control word sets, for each channel, whether its pin is driven and whether it counts edge-aligned or center-aligned. The same word also holds a burst bit that merges channel 1 into output 0 by an AND, and single-shot bits for the two upper channels.

Each channel raises a one-cycle pulse whenever it loads its shadow copies. An interrupt controller outside the block takes these pulses. A channel whose pin is disabled keeps counting and keeps producing these pulses, so it can serve as a pure timer. Software starts a channel with a run strobe and stops it with a clear strobe. In single-shot mode the hardware stops the channel by itself after one period.

Top module: `pwm4_unit`

## Requirements
- R1: After reset the control word reads 0000h and all channels are stopped. Control bits 8 to 11 and bit 13 are not stored and always read as 0, so writing FFFFh reads back D0FFh.
- R2: Control bits 3..0 are the output enables for channels 3..0. While a channel's bit is 0, its pin stays low, but the channel keeps counting and keeps producing its cycle-start pulses.
- R3: When a channel's mode bit (control bits 7..4 for channels 3..0) is 0, the channel runs edge-aligned. Its counter takes the values 0, 1, ... P and then returns to 0, so one cycle lasts P+1 clocks. The output is high when the count is at least the pulse width W.
- R4: When a channel's mode bit is 1, the channel runs center-aligned. Its counter takes the values 0, 1, ... P, then P-1, ... 1, and the next cycle starts at 0. One cycle lasts 2P clocks, or 1 clock when P is 0. The output is high when the count is at least W.
- R5: A pulse width of 0 gives an output that stays high for the whole cycle. A pulse width greater than the period gives an output that stays low for the whole cycle.
- R6: A write to the period or pulse-width value does not affect the cycle in progress. It takes effect only when the next cycle begins.
- R7: A channel's cycle-start output is high for exactly one clock each time the shadow copies are loaded. This happens on a start from the stopped state and at every cycle boundary. That clock is the one in which the new cycle's count of 0 is present.
- R8: When control bit 12 is 1, output 0 equals the enabled channel 0 signal ANDed with the raw channel 1 signal. When bit 12 is 0, output 0 follows channel 0 alone. Output 1 is unaffected by bit 12.
- R9: When control bit 14 is set (channel 2) or bit 15 is set (channel 3), that channel stops by itself at the end of one period. It then clears its run flag, drives its output low, holds its count at 0 and produces no cycle-start pulse. A later run strobe starts it again.
- R10: A run strobe on a stopped channel starts it at count 0 on the next clock. A clear strobe stops the channel and takes priority over the run strobe. A stopped channel drives its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_q | output | 16 | Stored control word |
| per_we | input | 4 | Per-channel period write strobes |
| pw_we | input | 4 | Per-channel pulse-width write strobes |
| val_wdata | input | W | Period or pulse-width write data |
| run_set | input | 4 | Per-channel start strobes |
| run_clr | input | 4 | Per-channel stop strobes |
| run_q | output | 4 | Per-channel run flags |
| pwm_out | output | 4 | PWM pins |
| cyc_start | output | 4 | Per-channel cycle-start pulses |

## Verification
Every result comes from a register that the strobe or the cycle boundary updates. The run flag, the count and the cycle-start pulse therefore appear one clock after a run strobe is taken, and the PWM pins follow combinationally from those registers in the same clock. A value written mid-cycle can only show after the next cycle-start pulse. The bench drives each strobe just after a rising edge and then lets exactly one edge pass. Sample k after a start therefore shows count k, and high times and pulse counts are summed over the exact number of clocks in one period given in R3 and R4. The single-shot stop is checked on the first sample after count P, and the mid-cycle write is checked both before and after the next pulse.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

   localparam int NCH       = 4;
   localparam int CW        = 16;
   localparam int SS_FIRST  = 2;
   localparam logic [CW-1:0] CTRL_MASK = 16'hD0FF;

   typedef struct packed {
      logic [1:0]     one_shot;   // [0] = channel 2, [1] = channel 3
      logic           burst;
      logic [NCH-1:0] center;
      logic [NCH-1:0] out_en;
   } pwm_cfg_t;

   function automatic pwm_cfg_t decode_ctrl(input logic [CW-1:0] w);
      pwm_cfg_t d;
      d.out_en   = w[3:0];
      d.center   = w[7:4];
      d.burst    = w[12];
      d.one_shot = w[15:14];
      return d;
   endfunction

endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
   import pwm4_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] q,
   output pwm_cfg_t      cfg
);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & CTRL_MASK;
   end

   assign cfg = decode_ctrl(q);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         per_we,
   input  logic         pw_we,
   input  logic [W-1:0] wdata,
   input  logic         center,
   input  logic         one_shot,
   input  logic         run_set,
   input  logic         run_clr,
   output logic         running,
   output logic         raw,
   output logic         cyc
);

   logic [W-1:0] per_q, pw_q, per_sh, pw_sh, cnt;
   logic         down, run, cyc_q;
   logic         at_top, end_evt;

   assign at_top  = (cnt == per_sh);
   assign end_evt = center ? ((!down && at_top && per_sh <= W'(1)) || (down && cnt == W'(1)))
                           : at_top;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q  <= '0;
         pw_q   <= '0;
         per_sh <= '0;
         pw_sh  <= '0;
         cnt    <= '0;
         down   <= 1'b0;
         run    <= 1'b0;
         cyc_q  <= 1'b0;
      end else begin
         if (per_we) per_q <= wdata;
         if (pw_we)  pw_q  <= wdata;
         cyc_q <= 1'b0;
         if (run_clr) begin
            run  <= 1'b0;
            cnt  <= '0;
            down <= 1'b0;
         end else if (!run) begin
            if (run_set) begin
               run    <= 1'b1;
               cnt    <= '0;
               down   <= 1'b0;
               per_sh <= per_q;
               pw_sh  <= pw_q;
               cyc_q  <= 1'b1;
            end
         end else if (end_evt) begin
            cnt  <= '0;
            down <= 1'b0;
            if (one_shot) begin
               run <= 1'b0;
            end else begin
               per_sh <= per_q;
               pw_sh  <= pw_q;
               cyc_q  <= 1'b1;
            end
         end else if (center && down) begin
            cnt <= cnt - W'(1);
         end else if (center && at_top) begin
            down <= 1'b1;
            cnt  <= cnt - W'(1);
         end else begin
            cnt <= cnt + W'(1);
         end
      end
   end

   assign running = run;
   assign raw     = run && (cnt >= pw_sh);
   assign cyc     = cyc_q;

endmodule

// File: rtl/pwm_outmux.sv
module pwm_outmux #(
   parameter int N = 4
) (
   input  logic [N-1:0] raw,
   input  logic [N-1:0] en,
   input  logic         burst,
   output logic [N-1:0] pins
);

   for (genvar i = 0; i < N; i++) begin : g_pin
      if (i == 0) begin : g_merge
         assign pins[i] = en[i] && raw[i] && (!burst || raw[1]);
      end else begin : g_plain
         assign pins[i] = en[i] && raw[i];
      end
   end

endmodule

// File: rtl/pwm4_unit.sv
module pwm4_unit
   import pwm4_pkg::*;
#(
   parameter int W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we,
   input  logic [15:0]   ctrl_wdata,
   output logic [15:0]   ctrl_q,
   input  logic [3:0]    per_we,
   input  logic [3:0]    pw_we,
   input  logic [W-1:0]  val_wdata,
   input  logic [3:0]    run_set,
   input  logic [3:0]    run_clr,
   output logic [3:0]    run_q,
   output logic [3:0]    pwm_out,
   output logic [3:0]    cyc_start
);

   if (W < 2) begin : g_bad_width
      $error("pwm4_unit: W must be at least 2");
   end
   if (NCH != 4 || CW != 16) begin : g_bad_layout
      $error("pwm4_unit: control layout assumes four channels and a 16-bit word");
   end

   pwm_cfg_t       cfg;
   logic [NCH-1:0] raw;

   pwm_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctrl_we),
      .wdata (ctrl_wdata),
      .q     (ctrl_q),
      .cfg   (cfg)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic ss_i;
      if (i >= SS_FIRST) begin : g_ss
         assign ss_i = cfg.one_shot[i-SS_FIRST];
      end else begin : g_nss
         assign ss_i = 1'b0;
      end

      pwm_chan #(.W(W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .per_we   (per_we[i]),
         .pw_we    (pw_we[i]),
         .wdata    (val_wdata),
         .center   (cfg.center[i]),
         .one_shot (ss_i),
         .run_set  (run_set[i]),
         .run_clr  (run_clr[i]),
         .running  (run_q[i]),
         .raw      (raw[i]),
         .cyc      (cyc_start[i])
      );
   end

   pwm_outmux #(.N(NCH)) u_mux (
      .raw   (raw),
      .en    (cfg.out_en),
      .burst (cfg.burst),
      .pins  (pwm_out)
   );

endmodule

// File: rtl/pwm4_chk.sv
module pwm4_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] ctrl_q,
   input logic [3:0]  run_clr,
   input logic [3:0]  run_q,
   input logic [3:0]  pwm_out,
   input logic [3:0]  cyc_start
);

   assert_ctrl_unused_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[11:8] == 4'h0) && !ctrl_q[13]);

   assert_burst_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[12] && ctrl_q[1] && pwm_out[0]) |-> pwm_out[1]);

   for (genvar i = 0; i < 4; i++) begin : g_lane
      assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q[i] |-> !pwm_out[i]);

      assert_stopped_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !run_q[i] |-> !pwm_out[i]);

      assert_pulse_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
         cyc_start[i] |-> run_q[i]);

      if (i >= 2) begin : g_ss
         assert_self_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(run_q[i]) && !$past(run_clr[i])) |-> $past(ctrl_q[12+i]));
      end else begin : g_nss
         assert_no_self_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run_q[i]) |-> $past(run_clr[i]));
      end
   end

endmodule

bind pwm4_unit pwm4_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_q    (ctrl_q),
   .run_clr   (run_clr),
   .run_q     (run_q),
   .pwm_out   (pwm_out),
   .cyc_start (cyc_start)
);

// File: tb/pwm4_unit_test.sv
module pwm4_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   // {center[64], period[63:48], width[47:32], expected high clocks[31:16], period clocks[15:0]}
   localparam logic [64:0] VEC [0:6] = '{
      {1'b0, 16'd7, 16'd3, 16'd5,  16'd8},
      {1'b0, 16'd5, 16'd0, 16'd6,  16'd6},
      {1'b0, 16'd4, 16'd9, 16'd0,  16'd5},
      {1'b1, 16'd4, 16'd2, 16'd5,  16'd8},
      {1'b1, 16'd3, 16'd0, 16'd6,  16'd6},
      {1'b1, 16'd6, 16'd5, 16'd3,  16'd12},
      {1'b0, 16'd0, 16'd0, 16'd1,  16'd1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctrl_we = 1'b0;
   logic [15:0]  ctrl_wdata = '0;
   logic [15:0]  ctrl_q;
   logic [3:0]   per_we = '0;
   logic [3:0]   pw_we = '0;
   logic [W-1:0] val_wdata = '0;
   logic [3:0]   run_set = '0;
   logic [3:0]   run_clr = '0;
   logic [3:0]   run_q;
   logic [3:0]   pwm_out;
   logic [3:0]   cyc_start;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm4_unit #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .ctrl_q(ctrl_q), .per_we(per_we), .pw_we(pw_we), .val_wdata(val_wdata),
      .run_set(run_set), .run_clr(run_clr), .run_q(run_q),
      .pwm_out(pwm_out), .cyc_start(cyc_start)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_ctrl(input logic [15:0] v);
      ctrl_wdata = v; ctrl_we = 1'b1; tick(); ctrl_we = 1'b0;
   endtask

   task automatic wr_per(input int ch, input int v);
      val_wdata = W'(v); per_we[ch] = 1'b1; tick(); per_we = '0;
   endtask

   task automatic wr_pw(input int ch, input int v);
      val_wdata = W'(v); pw_we[ch] = 1'b1; tick(); pw_we = '0;
   endtask

   task automatic start(input logic [3:0] m);
      run_set = m; tick(); run_set = '0;
   endtask

   task automatic stop_all();
      run_clr = 4'hF; tick(); run_clr = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hi, hi1, pl;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 / R10: reset state
      chk("R1 ctrl after reset", ctrl_q, 0);
      chk("R10 run flags after reset", run_q, 0);
      chk("R10 pins after reset", pwm_out, 0);
      chk("R7 no pulse after reset", cyc_start, 0);

      // R1: unstored bits
      wr_ctrl(16'hFFFF);
      chk("R1 readback of FFFFh", ctrl_q, 16'hD0FF);
      wr_ctrl(16'h0000);

      // R3 R4 R5 R7: vector table on channel 0
      for (int v = 0; v < 7; v++) begin
         string tag;
         logic [64:0] e;
         e = VEC[v];
         if (e[47:32] == 0 || e[47:32] > e[63:48]) tag = "R5";
         else tag = e[64] ? "R4" : "R3";
         stop_all();
         wr_ctrl(16'h000F | (16'(e[64]) << 4));
         wr_per(0, int'(e[63:48]));
         wr_pw(0, int'(e[47:32]));
         start(4'b0001);
         hi = 0; pl = 0;
         for (int j = 0; j < int'(e[15:0]); j++) begin
            hi += int'(pwm_out[0]);
            pl += int'(cyc_start[0]);
            tick();
         end
         chk({tag, " high clocks per cycle"}, hi, int'(e[31:16]));
         chk("R7 one pulse per cycle", pl, 1);
         chk("R7 pulse at next cycle start", int'(cyc_start[0]), 1);
      end

      // R6: mid-cycle pulse-width write waits for the next cycle
      stop_all();
      wr_ctrl(16'h000F);
      wr_per(0, 7);
      wr_pw(0, 3);
      start(4'b0001);
      tick(); tick();
      wr_pw(0, 6);                       // count now 3
      chk("R6 old width kept in current cycle", int'(pwm_out[0]), 1);
      repeat (5) tick();                 // count 0 of next cycle
      chk("R6 R7 pulse at reload", int'(cyc_start[0]), 1);
      repeat (4) tick();                 // count 4
      chk("R6 new width after reload", int'(pwm_out[0]), 0);

      // R2: disabled pin still pulses
      stop_all();
      wr_ctrl(16'h0007);
      wr_per(3, 2);
      wr_pw(3, 0);
      start(4'b1000);
      hi = 0; pl = 0;
      for (int j = 0; j < 6; j++) begin
         hi += int'(pwm_out[3]);
         pl += int'(cyc_start[3]);
         tick();
      end
      chk("R2 disabled pin stays low", hi, 0);
      chk("R2 disabled channel pulses", pl, 2);
      chk("R2 disabled channel still runs", int'(run_q[3]), 1);

      // R8: burst AND
      stop_all();
      wr_ctrl(16'h1003);
      wr_per(0, 7); wr_pw(0, 2);
      wr_per(1, 7); wr_pw(1, 5);
      start(4'b0011);
      hi = 0; hi1 = 0;
      for (int j = 0; j < 8; j++) begin
         hi  += int'(pwm_out[0]);
         hi1 += int'(pwm_out[1]);
         tick();
      end
      chk("R8 burst output 0 high clocks", hi, 3);
      chk("R8 output 1 unaffected", hi1, 3);
      stop_all();
      wr_ctrl(16'h0003);
      start(4'b0011);
      hi = 0;
      for (int j = 0; j < 8; j++) begin
         hi += int'(pwm_out[0]);
         tick();
      end
      chk("R8 independent output 0 high clocks", hi, 6);

      // R9: single shot on channel 2
      stop_all();
      wr_ctrl(16'h4004);
      wr_per(2, 3);
      wr_pw(2, 1);
      start(4'b0100);
      hi = 0;
      for (int j = 0; j < 4; j++) begin
         hi += int'(pwm_out[2]);
         tick();
      end
      chk("R9 one-shot high clocks", hi, 3);
      chk("R9 run flag cleared", int'(run_q[2]), 0);
      hi = 0; pl = 0;
      for (int j = 0; j < 5; j++) begin
         hi += int'(pwm_out[2]);
         pl += int'(cyc_start[2]);
         tick();
      end
      chk("R9 output low after stop", hi, 0);
      chk("R9 no pulse after stop", pl, 0);
      start(4'b0100);
      chk("R9 restart pulse", int'(cyc_start[2]), 1);
      chk("R9 restart runs", int'(run_q[2]), 1);

      // R10: clear wins over set, stopped pins low
      run_set = 4'hF; run_clr = 4'hF; tick(); run_set = '0; run_clr = '0;
      chk("R10 clear has priority", run_q, 0);
      chk("R10 stopped pins low", pwm_out, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule